// File: doc/BRIEF.md
# Core-Local Timer Interrupt Unit

This block is the per-hart interrupt source for machine software and machine timer interrupts. It holds a one-bit software-interrupt flag, a 64-bit compare value and a 64-bit timer. Software reaches all three through a simple 32-bit register port with address, write enable, write data and read data. The 64-bit registers are handled as two separate 32-bit words.

The timer does not count clock cycles. A prescaler counts cycles in which the event input is high, such as an instruction-retired strobe. After `PERIOD` such cycles the timer gains one and the prescaler restarts. The timer-pending output is a registered flag. It is re-evaluated as (timer >= compare) on each timer increment and on each software write to either 64-bit register. A reset clears it even though the cleared timer and compare values are equal.

Only the low 16 address bits are decoded, so the block repeats every 64 KiB. The upstream fabric is expected to route only this block's window to it.

Top module: `core_timer_irq`

## Requirements
- R1: After reset, every register reads 0x0000_0000 and both `msip_o` and `mtip_o` are low, until the first write or timer increment.
- R2: Only `addr_i[15:0]` is decoded. An access whose upper bits differ reaches the same register as its low 16 bits select.
- R3: Offset 0x0000 is the software-interrupt register. Write-data bit 0 sets `msip_o` after the write edge. Bits 31:1 always read as zero.
- R4: The compare value's low word is at 0x4000 and its high word at 0x4004. Each word reads back what was last written to it, and a write to one word leaves the other unchanged.
- R5: The timer's low word is at 0xBFF8 and its high word at 0xBFFC. Both are writable, and a write to one word leaves the other unchanged.
- R6: The timer gains exactly one after every `PERIOD` clock cycles in which `evt_i` is high, and the event count then restarts from zero. Cycles with `evt_i` low are not counted. With `PERIOD` = 1 the timer advances on every event cycle.
- R7: An increment is a full 64-bit add, so the low word wraps from 0xFFFF_FFFF to 0 and carries into the high word.
- R8: When a timer word is written in the same cycle that an increment is due, the written word takes the write data and the other word keeps its value. That increment is dropped, and the event count still restarts.
- R9: `mtip_o` is updated only at an edge with an increment or with a write to any compare or timer word. It then equals the unsigned comparison timer >= compare on the new register values. At all other edges it holds.
- R10: Reads at any other offset (for example 0x0004, 0x4008, 0xBFF4) return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Event strobe; each high cycle is one count toward the prescaler period |
| addr_i | input | ADDR_W | Register byte address; only bits 15:0 are decoded |
| we_i | input | 1 | Write enable for the addressed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| msip_o | output | 1 | Machine software-interrupt pending |
| mtip_o | output | 1 | Machine timer-interrupt pending |

## Verification
Assertions check four things on every cycle:
- The prescaler stays below its period.
- The timer gains exactly one on an increment edge without a write.
- The pending flag holds when nothing updates it, and equals the comparison after an update.
- A write to an undecoded offset leaves every register untouched.

Only the bench scenarios can show that the offsets map to the intended words, that the address alias works, and that the increment rate matches the period across idle gaps. They also cover the carry into the high word and the outcome when a timer write meets an increment in the same cycle. The bench also shows that reset clears the pending flag even though timer and compare are equal.

// File: rtl/core_timer_pkg.sv
package core_timer_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [15:0] OFS_SIP    = 16'h0000;
  localparam logic [15:0] OFS_CMP_LO = 16'h4000;
  localparam logic [15:0] OFS_CMP_HI = 16'h4004;
  localparam logic [15:0] OFS_TIM_LO = 16'hBFF8;
  localparam logic [15:0] OFS_TIM_HI = 16'hBFFC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SIP,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_TIM_LO,
    SEL_TIM_HI
  } reg_sel_e;

endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int unsigned PERIOD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic tick_o
);

  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = evt_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (evt_i)   cnt_q <= cnt_q + 1'b1;
  end

  initial begin
    if (PERIOD < 1) $error("evt_prescaler: PERIOD must be at least 1");
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cnt_q));

endmodule

// File: rtl/split_reg64.sv
module split_reg64 #(
  parameter int unsigned HALF_W  = 32,
  parameter bit          CAN_INC = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic                inc_i,
  output logic [2*HALF_W-1:0] q_o,
  output logic [2*HALF_W-1:0] d_o
);

  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] q;
  logic [FULL_W-1:0] bumped;
  logic              bump;

  assign bump   = CAN_INC & inc_i;
  assign bumped = q + FULL_W'(bump);

  // a write to either half wins over a pending increment
  always_comb begin
    d_o = bumped;
    if (wr_lo_i)      d_o = {q[FULL_W-1:HALF_W], wdata_i};
    else if (wr_hi_i) d_o = {wdata_i, q[HALF_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d_o;
  end

  assign q_o = q;

  generate
    if (CAN_INC) begin : g_inc_chk
      p_step_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_i && !wr_lo_i && !wr_hi_i |=> q == $past(q) + 1'b1);
    end else begin : g_hold_chk
      p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_lo_i && !wr_hi_i |=> $stable(q));
    end
  endgenerate

  p_lo_keep_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> q[FULL_W-1:HALF_W] == $past(q[FULL_W-1:HALF_W]));

endmodule

// File: rtl/timer_addr_dec.sv
module timer_addr_dec
  import core_timer_pkg::*;
(
  input  logic [15:0] ofs_i,
  output reg_sel_e    sel_o
);

  always_comb begin
    unique case (ofs_i)
      OFS_SIP:    sel_o = SEL_SIP;
      OFS_CMP_LO: sel_o = SEL_CMP_LO;
      OFS_CMP_HI: sel_o = SEL_CMP_HI;
      OFS_TIM_LO: sel_o = SEL_TIM_LO;
      OFS_TIM_HI: sel_o = SEL_TIM_HI;
      default:    sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/core_timer_irq.sv
module core_timer_irq
  import core_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PERIOD = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              msip_o,
  output logic              mtip_o
);

  localparam int unsigned FULL_W = 2 * WORD_W;

  reg_sel_e          sel;
  logic              tick;
  logic              wr_sip, wr_cmp_lo, wr_cmp_hi, wr_tim_lo, wr_tim_hi;
  logic              upd;
  logic [FULL_W-1:0] tim_q, tim_d, cmp_q, cmp_d;
  logic              sip_q, mtip_q;

  generate
    if (ADDR_W > 16) begin : g_hi_addr
      logic unused_hi_addr;
      assign unused_hi_addr = ^addr_i[ADDR_W-1:16];
    end
  endgenerate

  timer_addr_dec i_dec (
    .ofs_i (addr_i[15:0]),
    .sel_o (sel)
  );

  assign wr_sip    = we_i && (sel == SEL_SIP);
  assign wr_cmp_lo = we_i && (sel == SEL_CMP_LO);
  assign wr_cmp_hi = we_i && (sel == SEL_CMP_HI);
  assign wr_tim_lo = we_i && (sel == SEL_TIM_LO);
  assign wr_tim_hi = we_i && (sel == SEL_TIM_HI);

  evt_prescaler #(.PERIOD(PERIOD)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .tick_o (tick)
  );

  split_reg64 #(.HALF_W(WORD_W), .CAN_INC(1'b1)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_tim_lo),
    .wr_hi_i (wr_tim_hi),
    .wdata_i (wdata_i),
    .inc_i   (tick),
    .q_o     (tim_q),
    .d_o     (tim_d)
  );

  split_reg64 #(.HALF_W(WORD_W), .CAN_INC(1'b0)) i_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_cmp_lo),
    .wr_hi_i (wr_cmp_hi),
    .wdata_i (wdata_i),
    .inc_i   (1'b0),
    .q_o     (cmp_q),
    .d_o     (cmp_d)
  );

  assign upd = tick | wr_cmp_lo | wr_cmp_hi | wr_tim_lo | wr_tim_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sip_q  <= 1'b0;
      mtip_q <= 1'b0;
    end else begin
      if (wr_sip) sip_q  <= wdata_i[0];
      if (upd)    mtip_q <= (tim_d >= cmp_d);
    end
  end

  always_comb begin
    unique case (sel)
      SEL_SIP:    rdata_o = {{(WORD_W-1){1'b0}}, sip_q};
      SEL_CMP_LO: rdata_o = cmp_q[WORD_W-1:0];
      SEL_CMP_HI: rdata_o = cmp_q[FULL_W-1:WORD_W];
      SEL_TIM_LO: rdata_o = tim_q[WORD_W-1:0];
      SEL_TIM_HI: rdata_o = tim_q[FULL_W-1:WORD_W];
      default:    rdata_o = '0;
    endcase
  end

  assign msip_o = sip_q;
  assign mtip_o = mtip_q;

  p_msip_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sip |=> msip_o == $past(wdata_i[0]));

  p_mtip_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(mtip_o));

  p_mtip_eval_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> mtip_o == (tim_q >= cmp_q));

  p_undecoded_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (sel == SEL_NONE) && !tick |=>
      $stable(tim_q) && $stable(cmp_q) && $stable(msip_o));

endmodule

// File: tb/test_core_timer_irq.sv
module test_core_timer_irq;

  localparam int unsigned PER = 3;
  localparam int unsigned NV  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic [31:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        msip, mtip;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  core_timer_irq #(.ADDR_W(32), .PERIOD(PER)) i_core_timer_irq (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .evt_i   (evt),
    .addr_i  (addr),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .msip_o  (msip),
    .mtip_o  (mtip)
  );

  // {address, write data, expected read-back at the same address}
  localparam logic [95:0] VEC [NV] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001},  // R3
    {32'h0000_4000, 32'h1111_2222, 32'h1111_2222},  // R4
    {32'h0000_4004, 32'h3333_4444, 32'h3333_4444},  // R4
    {32'hABCD_4000, 32'h5555_6666, 32'h5555_6666},  // R2 alias
    {32'h0000_BFF8, 32'h7777_8888, 32'h7777_8888},  // R5
    {32'h0000_BFFC, 32'h9999_AAAA, 32'h9999_AAAA},  // R5
    {32'h0000_0004, 32'hDEAD_BEEF, 32'h0000_0000},  // R10
    {32'h0000_4008, 32'hCAFE_F00D, 32'h0000_0000},  // R10
    {32'h0000_BFF4, 32'h1234_5678, 32'h0000_0000},  // R10
    {32'h0001_0000, 32'h0000_0000, 32'h0000_0000}   // R2 alias
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt = 1'b1;
    end
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic check_reset(input string req);
    logic [31:0] v;
    rd(32'h0000_0000, v); check(req, v, 32'h0);
    rd(32'h0000_4000, v); check(req, v, 32'h0);
    rd(32'h0000_4004, v); check(req, v, 32'h0);
    rd(32'h0000_BFF8, v); check(req, v, 32'h0);
    rd(32'h0000_BFFC, v); check(req, v, 32'h0);
    check(req, {31'b0, msip}, 32'h0);
    check(req, {31'b0, mtip}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, mtip low though timer == compare
    check_reset("R1");

    // table of write/read-back vectors
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][95:64], VEC[k][63:32]);
      rd(VEC[k][95:64], v);
      check("R2/R3/R4/R5/R10 vector", v, VEC[k][31:0]);
    end
    rd(32'h0000_4000, v); check("R2 alias reached 0x4000", v, 32'h5555_6666);
    rd(32'h0000_4004, v); check("R10 cmp hi untouched", v, 32'h3333_4444);
    rd(32'h0000_BFF8, v); check("R10 timer lo untouched", v, 32'h7777_8888);
    rd(32'h0000_BFFC, v); check("R10 timer hi untouched", v, 32'h9999_AAAA);
    check("R9 mtip after writes", {31'b0, mtip}, 32'h1);

    // R3: software interrupt output
    wr(32'h0000_0000, 32'h0000_0001);
    check("R3 msip set", {31'b0, msip}, 32'h1);
    wr(32'h0000_0000, 32'hFFFF_FFFE);
    check("R3 msip clear by bit0", {31'b0, msip}, 32'h0);

    // R6/R9: prescaled counting toward compare 5
    wr(32'h0000_4000, 32'd5);
    wr(32'h0000_4004, 32'd0);
    wr(32'h0000_BFF8, 32'd0);
    wr(32'h0000_BFFC, 32'd0);
    check("R9 mtip low 0<5", {31'b0, mtip}, 32'h0);
    pulse(14);
    rd(32'h0000_BFF8, v); check("R6 14 events -> 4", v, 32'd4);
    check("R9 mtip low at 4", {31'b0, mtip}, 32'h0);
    pulse(1);
    rd(32'h0000_BFF8, v); check("R6 15 events -> 5", v, 32'd5);
    check("R9 mtip high at 5", {31'b0, mtip}, 32'h1);
    repeat (5) @(negedge clk);
    rd(32'h0000_BFF8, v); check("R6 idle not counted", v, 32'd5);
    pulse(1);
    repeat (2) @(negedge clk);
    pulse(1);
    rd(32'h0000_BFF8, v); check("R6 gap partial count", v, 32'd5);
    pulse(1);
    rd(32'h0000_BFF8, v); check("R6 gap third event", v, 32'd6);
    wr(32'h0000_4000, 32'd100);
    check("R9 mtip re-evaluated on cmp write", {31'b0, mtip}, 32'h0);

    // R7: carry into high word
    wr(32'h0000_BFF8, 32'hFFFF_FFFF);
    pulse(3);
    rd(32'h0000_BFF8, v); check("R7 low wraps", v, 32'h0);
    rd(32'h0000_BFFC, v); check("R7 carry to high", v, 32'h1);
    check("R9 mtip after carry", {31'b0, mtip}, 32'h1);

    // R8: write coincides with increment
    pulse(2);
    @(negedge clk);
    evt = 1'b1; we = 1'b1; addr = 32'h0000_BFF8; wdata = 32'h0000_0100;
    @(negedge clk);
    evt = 1'b0; we = 1'b0;
    rd(32'h0000_BFF8, v); check("R8 written low wins", v, 32'h0000_0100);
    rd(32'h0000_BFFC, v); check("R8 high kept", v, 32'h1);
    pulse(3);
    rd(32'h0000_BFF8, v); check("R8 count restarted", v, 32'h0000_0101);

    // R6: reset mid-run then R1 again
    wr(32'h0000_0000, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset("R1 after mid-run reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule